// File: doc/BRIEF.md
# Cycling Perfect-Shuffle Bitonic Merger

This block merges two sorted lists of `HALF_N` keys each into one ascending list of `2*HALF_N` keys. The first list arrives in ascending order and the second in descending order, so the two together form a bitonic sequence. A start pulse loads both lists into a bank of `2*HALF_N` key registers. Each following clock cycle applies a perfect shuffle to the bank and passes every adjacent pair through one of `HALF_N` fixed compare-exchange units. These units sit at the same positions on every pass.

After log2(2*HALF_N) passes the bank is back in its natural index order and holds the merged result. At that point a done flag rises for one clock. Unsigned keys are compared. A start pulse that arrives while a merge is running has no effect. The result stays on the output until the next accepted start.

Top module: `bitonicShuffleMerger`

## Requirements
- R1: Key i of each input vector sits at bits `[i*KEY_W +: KEY_W]`. `listAsc` holds keys in ascending order from index 0. `listDesc` holds keys in descending order from index 0.
- R2: When `start` is high at a rising clock edge while no merge is running, the block accepts the inputs and begins a merge.
- R3: When `done` is high, `merged` holds the keys in ascending unsigned order, with the smallest key at index 0 (bits `[KEY_W-1:0]`).
- R4: `merged` is a permutation of the 2*HALF_N accepted keys. No key is lost or duplicated, including when keys repeat within or across the lists.
- R5: `done` rises exactly log2(2*HALF_N) clock edges after the edge that accepted `start`.
- R6: `done` stays high for exactly one clock cycle per merge.
- R7: A `start` pulse that arrives while a merge is running is ignored. The result and the timing of `done` are those of the merge already running.
- R8: After reset, `done` is low and `merged` is all zeros.
- R9: After `done`, `merged` holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load both lists and begin merging |
| listAsc | input | HALF_N*KEY_W | First list, ascending from index 0 |
| listDesc | input | HALF_N*KEY_W | Second list, descending from index 0 |
| merged | output | 2*HALF_N*KEY_W | Register bank; holds the merged ascending list once `done` rises |
| done | output | 1 | One-cycle pulse marking a finished merge |

## Verification
A fault in the shuffle wiring or in a compare-exchange unit shows up at the ports as unsorted or lost keys. It appears on the very cycle `done` rises. An off-by-one in the pass counter has two effects: `done` moves by a cycle, and the bank is left in rotated index order, so the output is a scrambled version of the sorted list. A control path that wrongly accepts a start in mid-merge reloads the bank. The result then differs from the first merge, or `done` arrives late. The bench covers many random sorted lists drawn from a narrow key range, so duplicate keys are common. It also applies fixed patterns where one list lies wholly below or above the other.

// File: rtl/shuffleMergePkg.sv
package shuffleMergePkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic load;  // capture the two input lists into the bank
    logic step;  // apply one shuffle plus compare-exchange pass
  } mergeStrobes_t;
endpackage

// File: rtl/cmpExch.sv
module cmpExch #(
  parameter int KEY_W = 8
) (
  input  logic [KEY_W-1:0] keyA,
  input  logic [KEY_W-1:0] keyB,
  output logic [KEY_W-1:0] keyLo,
  output logic [KEY_W-1:0] keyHi
);
  logic swapNeeded;
  assign swapNeeded = keyA > keyB;
  assign keyLo = swapNeeded ? keyB : keyA;
  assign keyHi = swapNeeded ? keyA : keyB;
endmodule

// File: rtl/mergeCtrl.sv
module mergeCtrl
  import shuffleMergePkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output mergeStrobes_t strobes,
  output logic          done
);
  localparam int CNT_W = (STAGES < 2) ? 1 : $clog2(STAGES + 1);
  localparam logic [CNT_W-1:0] LAST_PASS = CNT_W'(STAGES - 1);

  logic             busy;
  logic [CNT_W-1:0] passCnt;
  logic             finalPass;

  assign strobes.load = start && !busy;
  assign strobes.step = busy;
  assign finalPass    = busy && (passCnt == LAST_PASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      passCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= finalPass;
      if (strobes.load) begin
        busy    <= 1'b1;
        passCnt <= '0;
      end else if (busy) begin
        if (finalPass) begin
          busy    <= 1'b0;
          passCnt <= '0;
        end else begin
          passCnt <= passCnt + CNT_W'(1);
        end
      end
    end
  end

  // R6: done is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: done follows the final pass of a running merge
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && $past(passCnt) == LAST_PASS));

  // R7: a start during a merge neither restarts nor stalls the pass count
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && passCnt != LAST_PASS) |=> (busy && passCnt == $past(passCnt) + CNT_W'(1)));
endmodule

// File: rtl/mergeDatapath.sv
module mergeDatapath
  import shuffleMergePkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int HALF_N = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  mergeStrobes_t              strobes,
  input  logic [HALF_N*KEY_W-1:0]    listAsc,
  input  logic [HALF_N*KEY_W-1:0]    listDesc,
  output logic [2*HALF_N*KEY_W-1:0]  merged
);
  localparam int TOTAL = 2 * HALF_N;
  localparam int SUM_W = KEY_W + $clog2(TOTAL) + 1;

  logic [KEY_W-1:0] bank      [TOTAL];
  logic [KEY_W-1:0] shuffled  [TOTAL];
  logic [KEY_W-1:0] exchanged [TOTAL];

  // Perfect shuffle: lower half goes to even wires, upper half to odd wires,
  // then one fixed compare-exchange per adjacent pair.
  for (genvar i = 0; i < HALF_N; i++) begin : g_pair
    assign shuffled[2*i]   = bank[i];
    assign shuffled[2*i+1] = bank[i+HALF_N];
    cmpExch #(.KEY_W(KEY_W)) u_cmpExch (
      .keyA (shuffled[2*i]),
      .keyB (shuffled[2*i+1]),
      .keyLo(exchanged[2*i]),
      .keyHi(exchanged[2*i+1])
    );
  end

  for (genvar i = 0; i < TOTAL; i++) begin : g_out
    assign merged[i*KEY_W +: KEY_W] = bank[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) bank[i] <= '0;
    end else if (strobes.load) begin
      for (int i = 0; i < HALF_N; i++) begin
        bank[i]          <= listAsc[i*KEY_W +: KEY_W];
        bank[i + HALF_N] <= listDesc[i*KEY_W +: KEY_W];
      end
    end else if (strobes.step) begin
      for (int i = 0; i < TOTAL; i++) bank[i] <= exchanged[i];
    end
  end

  logic [SUM_W-1:0] bankSum;
  always_comb begin
    bankSum = '0;
    for (int i = 0; i < TOTAL; i++) bankSum = bankSum + SUM_W'(bank[i]);
  end

  // R4: a pass only moves keys around, so their total is unchanged
  p_sum_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && !strobes.load) |=> (bankSum == $past(bankSum)));

  // R9: with no strobe the bank holds its contents
  p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.step && !strobes.load) |=> $stable(merged));
endmodule

// File: rtl/bitonicShuffleMerger.sv
module bitonicShuffleMerger
  import shuffleMergePkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int HALF_N = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [HALF_N*KEY_W-1:0]    listAsc,
  input  logic [HALF_N*KEY_W-1:0]    listDesc,
  output logic [2*HALF_N*KEY_W-1:0]  merged,
  output logic                       done
);
  localparam int TOTAL  = 2 * HALF_N;
  localparam int STAGES = $clog2(TOTAL);

  mergeStrobes_t strobes;

  mergeCtrl #(.STAGES(STAGES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strobes(strobes),
    .done   (done)
  );

  mergeDatapath #(.KEY_W(KEY_W), .HALF_N(HALF_N)) u_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .listAsc (listAsc),
    .listDesc(listDesc),
    .merged  (merged)
  );

  logic mergedSorted;
  always_comb begin
    mergedSorted = 1'b1;
    for (int i = 1; i < TOTAL; i++)
      if (merged[(i-1)*KEY_W +: KEY_W] > merged[i*KEY_W +: KEY_W]) mergedSorted = 1'b0;
  end

  // R3: whenever done is raised, the output is ascending
  p_sorted_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mergedSorted);
endmodule

// File: tb/test_bitonicShuffleMerger.sv
module test_bitonicShuffleMerger;
  localparam int KEY_W  = 4;
  localparam int HALF_N = 4;
  localparam int TOTAL  = 2 * HALF_N;
  localparam int STAGES = $clog2(TOTAL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [HALF_N*KEY_W-1:0] listAsc = '0;
  logic [HALF_N*KEY_W-1:0] listDesc = '0;
  logic [TOTAL*KEY_W-1:0]  merged;
  logic done;

  int applied = 0;
  int failed  = 0;
  bit finished = 0;

  int aKeys [HALF_N];
  int bKeys [HALF_N];
  int expKeys [TOTAL];

  always #4 clk = ~clk;  // 125 MHz

  bitonicShuffleMerger #(.KEY_W(KEY_W), .HALF_N(HALF_N)) i_bitonicShuffleMerger (
    .clk(clk), .rst_n(rst_n), .start(start),
    .listAsc(listAsc), .listDesc(listDesc),
    .merged(merged), .done(done)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    applied++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic void sortA();
    for (int i = 0; i < HALF_N; i++)
      for (int j = 0; j < HALF_N - 1 - i; j++)
        if (aKeys[j] > aKeys[j+1]) begin int t = aKeys[j]; aKeys[j] = aKeys[j+1]; aKeys[j+1] = t; end
  endfunction

  function automatic void sortB();
    for (int i = 0; i < HALF_N; i++)
      for (int j = 0; j < HALF_N - 1 - i; j++)
        if (bKeys[j] > bKeys[j+1]) begin int t = bKeys[j]; bKeys[j] = bKeys[j+1]; bKeys[j+1] = t; end
  endfunction

  // Expected result: full ascending sort of all keys, computed in the bench.
  function automatic logic [TOTAL*KEY_W-1:0] expected();
    logic [TOTAL*KEY_W-1:0] v;
    for (int i = 0; i < HALF_N; i++) begin expKeys[i] = aKeys[i]; expKeys[HALF_N+i] = bKeys[i]; end
    for (int i = 0; i < TOTAL; i++)
      for (int j = 0; j < TOTAL - 1 - i; j++)
        if (expKeys[j] > expKeys[j+1]) begin int t = expKeys[j]; expKeys[j] = expKeys[j+1]; expKeys[j+1] = t; end
    for (int i = 0; i < TOTAL; i++) v[i*KEY_W +: KEY_W] = KEY_W'(expKeys[i]);
    return v;
  endfunction

  // aKeys, bKeys ascending; listDesc gets bKeys reversed (R1)
  task automatic runMerge(input bit extraStart);
    logic [TOTAL*KEY_W-1:0] exp;
    logic [TOTAL*KEY_W-1:0] held;
    exp = expected();
    @(negedge clk);
    for (int i = 0; i < HALF_N; i++) begin
      listAsc[i*KEY_W +: KEY_W]  = KEY_W'(aKeys[i]);
      listDesc[i*KEY_W +: KEY_W] = KEY_W'(bKeys[HALF_N-1-i]);
    end
    start = 1'b1;
    @(posedge clk);  // accepting edge (R2)
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= STAGES; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 1 && extraStart) begin
        listAsc  = ~listAsc;   // R7: a different request while busy
        listDesc = '0;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (c < STAGES) check("R5 done early", 64'(done), 64'd0);
    end
    start = 1'b0;
    check("R5/R6 done at final pass", 64'(done), 64'd1);
    check(extraStart ? "R7 result unaffected" : "R3/R4 merged result", 64'(merged), 64'(exp));
    held = merged;
    @(posedge clk);
    @(negedge clk);
    check("R6 done one cycle", 64'(done), 64'd0);
    check("R9 result held", 64'(merged), 64'(held));
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    check("R8 done after reset", 64'(done), 64'd0);
    check("R8 merged after reset", 64'(merged), 64'd0);
    rst_n = 1'b1;

    // R1/R3: first list wholly below the second
    for (int i = 0; i < HALF_N; i++) begin aKeys[i] = i; bKeys[i] = 8 + i; end
    runMerge(0);
    // first list wholly above the second
    for (int i = 0; i < HALF_N; i++) begin aKeys[i] = 12 + i; bKeys[i] = i; end
    runMerge(0);
    // R4: all keys equal
    for (int i = 0; i < HALF_N; i++) begin aKeys[i] = 5; bKeys[i] = 5; end
    runMerge(0);
    // perfect interleave
    for (int i = 0; i < HALF_N; i++) begin aKeys[i] = 2*i; bKeys[i] = 2*i + 1; end
    runMerge(0);
    // extremes of the key range
    for (int i = 0; i < HALF_N; i++) begin aKeys[i] = 0; bKeys[i] = 15; end
    runMerge(0);

    // random sorted lists, narrow range so duplicates are frequent (R4)
    for (int v = 0; v < 400; v++) begin
      for (int i = 0; i < HALF_N; i++) begin
        aKeys[i] = int'($urandom_range(0, (v % 2) ? 15 : 3));
        bKeys[i] = int'($urandom_range(0, (v % 3) ? 15 : 3));
      end
      sortA();
      sortB();
      runMerge(v % 5 == 0);
    end

    // R7 with a fixed pattern as well
    for (int i = 0; i < HALF_N; i++) begin aKeys[i] = 3 + i; bKeys[i] = 1 + 2*i; end
    runMerge(1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule